// File: doc/BRIEF.md
# Secure Cache Auxiliary Configuration Register

This block holds a 32-bit configuration word for a second-level cache controller. It sits behind a single-beat register request port. Each request carries a write flag and a security attribute. One cycle after each request the block returns a response code and, for reads, the stored word. Writes are accepted only when they are secure and the cache is switched off. Any other write is refused with an error code and leaves the stored word unchanged.

The stored word drives a set of decoded controls: instruction and data prefetch enables, the replacement-policy select, the effective write-allocate decision for the current write, the way size in kilobytes and the number of ways. The readback always returns the raw stored field values. The decoded outputs fold the reserved encodings of the write-allocate and way-size fields into legal ones. At reset, the way-size and associativity fields load from tie-off inputs.

Top module: `cache_aux_cfg_reg`

## Requirements
- R1: A write with `req_secure`=0 returns DECERR (`rsp_code`=2'b11) and leaves the stored word unchanged.
- R2: A secure write while `cache_en`=1 returns SLVERR (`rsp_code`=2'b10) and leaves the stored word unchanged.
- R3: A write that is both non-secure and made while `cache_en`=1 returns DECERR, not SLVERR.
- R4: A read with either security attribute returns OKAY (`rsp_code`=2'b00) and the current stored word on `rsp_rdata`.
- R5: Bits 31, 15:14 and 9:1 always read as zero, and values written to them are discarded.
- R6: After reset the word reads as bit 25 = 1, bits 19:17 = `tie_way_size`, bit 16 = `tie_assoc`, and every other bit = 0.
- R7: A secure write with `cache_en`=0 returns OKAY in the cycle after the request. From that cycle on, all non-reserved bits hold the written data.
- R8: `wr_alloc_eff` decodes bits 24:23 as follows: 01 gives 0, 10 gives 1, and 00 or 11 give `awcache_wa`. The output is combinational in `awcache_wa`.
- R9: `way_size_kb` decodes bits 19:17 as follows: codes 1 to 6 give 16 << (code-1), code 0 gives 16, and code 7 gives 512.
- R10: `num_ways` is 8 when bit 16 is 0 and 16 when bit 16 is 1.
- R11: `repl_round_robin` follows bit 25, `iprefetch_en` follows bit 29 and `dprefetch_en` follows bit 28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Security attribute of the request |
| req_wdata | input | 32 | Write data |
| cache_en | input | 1 | Cache-enable state from the control register |
| tie_way_size | input | 3 | Reset value of the way-size field |
| tie_assoc | input | 1 | Reset value of the associativity bit |
| awcache_wa | input | 1 | Write-allocate attribute of the current bus write |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 2 | 00 OKAY, 10 SLVERR, 11 DECERR |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| iprefetch_en | output | 1 | Instruction prefetch enable |
| dprefetch_en | output | 1 | Data prefetch enable |
| repl_round_robin | output | 1 | 1 = round-robin, 0 = pseudo-random |
| wr_alloc_eff | output | 1 | Effective write-allocate decision |
| way_size_kb | output | 10 | Effective way size in KB |
| num_ways | output | 5 | Associativity |

## Verification
The hardest case to reach is a refused write that would have changed the word. To reach it, the bench first loads a known word through a secure write with the cache off. It then sends an all-ones write under each security and cache-enable combination. Afterwards it reads the word back, so a corrupted update shows at the ports. The reserved way-size and write-allocate codes can only be reached by deliberate writes, so the bench sweeps both fields through every encoding.

// File: rtl/cache_aux_cfg_pkg.sv
package cache_aux_cfg_pkg;
    localparam int DATA_W   = 32;
    localparam int KB_W     = 10;
    localparam int WAYS_W   = 5;

    typedef enum logic [1:0] {
        RSP_OKAY   = 2'b00,
        RSP_SLVERR = 2'b10,
        RSP_DECERR = 2'b11
    } rsp_e;

    localparam logic [DATA_W-1:0] RSVD_BITS = 32'h8000_C3FE;
    localparam logic [DATA_W-1:0] KEEP_BITS = ~RSVD_BITS;

    localparam int POS_IPF   = 29;
    localparam int POS_DPF   = 28;
    localparam int POS_REPL  = 25;
    localparam int POS_WA_LO = 23;
    localparam int POS_WAY   = 17;
    localparam int POS_ASSOC = 16;

    typedef struct packed {
        logic [DATA_W-1:0] cfg;
        logic              rsp_valid;
        rsp_e              rsp_code;
        logic [DATA_W-1:0] rsp_rdata;
    } state_t;
endpackage

// File: rtl/cfg_access_gate.sv
module cfg_access_gate
    import cache_aux_cfg_pkg::*;
(
    input  logic req_valid,
    input  logic req_write,
    input  logic req_secure,
    input  logic cache_en,
    output logic commit,
    output rsp_e code
);
    always_comb begin
        commit = 1'b0;
        code   = RSP_OKAY;
        if (req_valid && req_write) begin
            if (!req_secure) begin
                code = RSP_DECERR;
            end else if (cache_en) begin
                code = RSP_SLVERR;
            end else begin
                commit = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cfg_field_decode.sv
module cfg_field_decode
    import cache_aux_cfg_pkg::*;
#(
    parameter int MIN_WAY_KB = 16,
    parameter int WAY_CODE_W = 3
) (
    input  logic [DATA_W-1:0] cfg,
    input  logic              awcache_wa,
    output logic              iprefetch_en,
    output logic              dprefetch_en,
    output logic              repl_round_robin,
    output logic              wr_alloc_eff,
    output logic [KB_W-1:0]   way_size_kb,
    output logic [WAYS_W-1:0] num_ways
);
    localparam logic [WAY_CODE_W-1:0] CODE_LO = WAY_CODE_W'(1);
    localparam logic [WAY_CODE_W-1:0] CODE_HI = {WAY_CODE_W{1'b1}} - WAY_CODE_W'(1);

    logic [1:0]            wa_field;
    logic [WAY_CODE_W-1:0] way_raw;
    logic [WAY_CODE_W-1:0] way_sel;

    always_comb begin
        iprefetch_en     = cfg[POS_IPF];
        dprefetch_en     = cfg[POS_DPF];
        repl_round_robin = cfg[POS_REPL];
        wa_field         = cfg[POS_WA_LO +: 2];
        case (wa_field)
            2'b01:   wr_alloc_eff = 1'b0;
            2'b10:   wr_alloc_eff = 1'b1;
            default: wr_alloc_eff = awcache_wa;
        endcase
        way_raw = cfg[POS_WAY +: WAY_CODE_W];
        if (way_raw < CODE_LO) begin
            way_sel = CODE_LO;
        end else if (way_raw > CODE_HI) begin
            way_sel = CODE_HI;
        end else begin
            way_sel = way_raw;
        end
        way_size_kb = KB_W'(MIN_WAY_KB) << (way_sel - CODE_LO);
        num_ways    = cfg[POS_ASSOC] ? WAYS_W'(16) : WAYS_W'(8);
    end
endmodule

// File: rtl/cache_aux_cfg_reg.sv
module cache_aux_cfg_reg
    import cache_aux_cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic        req_secure,
    input  logic [31:0] req_wdata,
    input  logic        cache_en,
    input  logic [2:0]  tie_way_size,
    input  logic        tie_assoc,
    input  logic        awcache_wa,
    output logic        rsp_valid,
    output logic [1:0]  rsp_code,
    output logic [31:0] rsp_rdata,
    output logic        iprefetch_en,
    output logic        dprefetch_en,
    output logic        repl_round_robin,
    output logic        wr_alloc_eff,
    output logic [9:0]  way_size_kb,
    output logic [4:0]  num_ways
);
    state_t st_d, st_q;
    logic   commit;
    rsp_e   gate_code;

    cfg_access_gate u_gate (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_secure(req_secure),
        .cache_en  (cache_en),
        .commit    (commit),
        .code      (gate_code)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = req_valid;
        st_d.rsp_code  = gate_code;
        st_d.rsp_rdata = '0;
        if (req_valid && !req_write) begin
            st_d.rsp_rdata = st_q.cfg;
        end
        if (commit) begin
            st_d.cfg = req_wdata & KEEP_BITS;
        end
        if (!rst_n) begin
            st_d.cfg                         = '0;
            st_d.cfg[POS_REPL]               = 1'b1;
            st_d.cfg[POS_WAY +: 3]           = tie_way_size;
            st_d.cfg[POS_ASSOC]              = tie_assoc;
            st_d.rsp_valid                   = 1'b0;
            st_d.rsp_code                    = RSP_OKAY;
            st_d.rsp_rdata                   = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_code  = st_q.rsp_code;
    assign rsp_rdata = st_q.rsp_rdata;

    cfg_field_decode u_dec (
        .cfg             (st_q.cfg),
        .awcache_wa      (awcache_wa),
        .iprefetch_en    (iprefetch_en),
        .dprefetch_en    (dprefetch_en),
        .repl_round_robin(repl_round_robin),
        .wr_alloc_eff    (wr_alloc_eff),
        .way_size_kb     (way_size_kb),
        .num_ways        (num_ways)
    );

    AST_NS_WRITE_DECERR: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write && !req_secure |=> rsp_code == 2'b11); // R3
    AST_NS_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write && !req_secure |=> $stable(st_q.cfg)); // R1
    AST_ENABLED_SLVERR: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write && req_secure && cache_en |=> rsp_code == 2'b10 && $stable(st_q.cfg)); // R2
    AST_READ_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write |=> rsp_valid && rsp_code == 2'b00 && rsp_rdata == $past(st_q.cfg)); // R4
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_rdata & RSVD_BITS) == '0); // R5
    AST_WAY_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(way_size_kb) && way_size_kb >= 10'd16 && way_size_kb <= 10'd512); // R9
    AST_WAYS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        num_ways == 5'd8 || num_ways == 5'd16); // R10
endmodule

// File: tb/cache_aux_cfg_reg_bench.sv
module cache_aux_cfg_reg_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        cache_en = 1'b0;
    logic [2:0]  tie_way_size = 3'b011;
    logic        tie_assoc = 1'b1;
    logic        awcache_wa = 1'b0;
    logic        rsp_valid;
    logic [1:0]  rsp_code;
    logic [31:0] rsp_rdata;
    logic        iprefetch_en, dprefetch_en, repl_round_robin, wr_alloc_eff;
    logic [9:0]  way_size_kb;
    logic [4:0]  num_ways;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    localparam logic [31:0] KEEP = 32'h7FFF_3C01;

    always #5 clk = ~clk;

    cache_aux_cfg_reg u_cache_aux_cfg_reg (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic sec, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_secure = sec; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic load(input logic [31:0] d);
        logic saved;
        saved = cache_en;
        cache_en = 1'b0;
        access(1'b1, 1'b1, d);
        cache_en = saved;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6 reset state
        access(1'b0, 1'b1, '0);
        check("R6 reset word", rsp_rdata, 32'h0200_0000 | (32'(3) << 17) | (32'(1) << 16));
        check("R11 reset repl", 32'(repl_round_robin), 32'd1);
        check("R9 reset way", 32'(way_size_kb), 32'd64);
        check("R10 reset ways", 32'(num_ways), 32'd16);
        check("R4 read code", 32'(rsp_code), 32'd0);

        // R1 R2 R3 gating sweep, R5 reserved masking, R7 commit
        for (int s = 0; s < 2; s++) begin
            for (int c = 0; c < 2; c++) begin
                logic [1:0]  ec;
                logic [31:0] ew;
                load(32'h0000_0000);
                cache_en = c[0];
                access(1'b1, s[0], 32'hFFFF_FFFF);
                ec = (s == 0) ? 2'b11 : (c == 1) ? 2'b10 : 2'b00;
                ew = (s == 1 && c == 0) ? KEEP : 32'h0;
                if (s == 0) check($sformatf("R1 R3 ns write code c=%0d", c), 32'(rsp_code), 32'(ec));
                else        check($sformatf("R2 R7 sec write code c=%0d", c), 32'(rsp_code), 32'(ec));
                check("R7 rsp valid", 32'(rsp_valid), 32'd1);
                cache_en = 1'b0;
                access(1'b0, 1'b0, '0);
                check($sformatf("R1 R2 R5 readback s=%0d c=%0d", s, c), rsp_rdata, ew);
                check("R4 ns read okay", 32'(rsp_code), 32'd0);
            end
        end

        // R9 way size sweep incl. reserved codes
        for (int f = 0; f < 8; f++) begin
            int sel;
            load(32'(f) << 17);
            sel = (f == 0) ? 1 : (f == 7) ? 6 : f;
            check($sformatf("R9 way code %0d", f), 32'(way_size_kb), 32'(16 << (sel - 1)));
            access(1'b0, 1'b1, '0);
            check("R7 raw readback", rsp_rdata, 32'(f) << 17);
        end

        // R10 associativity
        for (int a = 0; a < 2; a++) begin
            load(32'(a) << 16);
            check("R10 ways", 32'(num_ways), (a == 1) ? 32'd16 : 32'd8);
        end

        // R8 write-allocate sweep
        for (int e = 0; e < 4; e++) begin
            load(32'(e) << 23);
            for (int w = 0; w < 2; w++) begin
                awcache_wa = w[0];
                #1;
                check($sformatf("R8 wa field %0d awcache %0d", e, w), 32'(wr_alloc_eff),
                      (e == 1) ? 32'd0 : (e == 2) ? 32'd1 : 32'(w));
            end
        end

        // R11 prefetch and replacement bits
        for (int p = 0; p < 8; p++) begin
            load((32'(p & 1) << 25) | (32'((p >> 1) & 1) << 28) | (32'((p >> 2) & 1) << 29));
            check("R11 repl", 32'(repl_round_robin), 32'(p & 1));
            check("R11 dprefetch", 32'(dprefetch_en), 32'((p >> 1) & 1));
            check("R11 iprefetch", 32'(iprefetch_en), 32'((p >> 2) & 1));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule